// File: doc/BRIEF.md
# Armed pulse decimator

This block counts short external pulses against a programmed ratio. It runs in the domain of one system clock. It stays idle until a start request arrives. At that point it takes a copy of the 16-bit ratio and begins to count rising edges of the pulse input. When the last pulse of the run arrives, it raises its output for exactly one clock and goes back to idle. The next run needs another start request.

The pulse and start inputs come from outside the clock domain. Each one passes through a two-stage synchronizer and is then edge-detected. A pulse that stays high for several clocks therefore adds one to the count, not one per cycle. The pulse input is only sampled as data and never used as a clock. An asynchronous active-high reset stops any run at once.

Top module: `pulse_decimator`

## Requirements
- R1: Each low-to-high transition of the synchronized pulse input adds exactly one to the run count, however many clocks the pulse stays high.
- R2: While idle, pulses on the pulse input are ignored: no output pulse is produced and no count builds up.
- R3: After a start is accepted with ratio N (N from 1 to 65535, unsigned), fire_out goes high after exactly N pulses and not after N-1.
- R4: A ratio of 0 acts as a ratio of 1, so the first pulse after start fires the output.
- R5: Once a run is under way, further start requests are ignored. Changes to ratio_in have no effect, because the ratio was captured when start was accepted.
- R6: busy_out goes high when start is accepted, stays high for the whole run, and goes low in the same cycle that fire_out goes high. It is low while idle.
- R7: Asserting rst forces busy_out and fire_out low and clears the run without waiting for a clock edge. After reset, pulses are ignored until a new start.
- R8: fire_out is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| start_in | input | 1 | Asynchronous start request; its rising edge arms a run |
| pulse_in | input | 1 | Asynchronous pulses to be counted |
| ratio_in | input | 16 | Number of pulses per output pulse (0 behaves as 1) |
| fire_out | output | 1 | One-cycle pulse when the run completes |
| busy_out | output | 1 | High while a run is counting |

## Verification
Some properties are checked on every clock:
- the output pulse lasts one cycle and ends the busy interval;
- the count holds still when no pulse edge arrives;
- the captured ratio stays constant during a run;
- the count never reaches the ratio;
- a pulse edge seen while idle cannot fire the output;
- reset holds both outputs low.

Other behaviour can only be shown by the bench scenarios. These cover the exact number of pulses needed to fire across several ratios, including 0 and a value above 255, and a single long pulse counting once. They also cover restart requests and ratio changes in the middle of a run, and an abort by reset in the middle of a run.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

    typedef enum logic {
        PD_IDLE = 1'b0,
        PD_RUN  = 1'b1
    } pd_state_e;

    // Asynchronous inputs carried together through synchronizer and edge stage
    typedef struct packed {
        logic start;
        logic pulse;
    } pd_in_s;

    localparam int PD_IN_W = $bits(pd_in_s);

endpackage

// File: rtl/pdec_sync.sv
module pdec_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) pipe[0] <= '0;
        else     pipe[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or posedge rst) begin
            if (rst) pipe[s] <= '0;
            else     pipe[s] <= pipe[s-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pdec_edge.sv
module pdec_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) prev <= '0;
        else     prev <= lvl;
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/pdec_ctrl.sv
module pdec_ctrl
    import pdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_rise,
    input  logic             pulse_rise,
    input  logic [CNT_W-1:0] ratio,
    output logic             fire,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] target
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pd_state_e state;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state  <= PD_IDLE;
            cnt    <= '0;
            target <= '0;
            fire   <= 1'b0;
        end else begin
            fire <= 1'b0;
            unique case (state)
                PD_IDLE: begin
                    if (start_rise) begin
                        state  <= PD_RUN;
                        cnt    <= '0;
                        target <= (ratio == '0) ? ONE : ratio;
                    end
                end
                PD_RUN: begin
                    if (pulse_rise) begin
                        if (cnt == target - ONE) begin
                            fire  <= 1'b1;
                            state <= PD_IDLE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + ONE;
                        end
                    end
                end
                default: state <= PD_IDLE;
            endcase
        end
    end

    assign busy = (state == PD_RUN);
endmodule

// File: rtl/pulse_decimator.sv
module pulse_decimator
    import pdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_in,
    input  logic             pulse_in,
    input  logic [CNT_W-1:0] ratio_in,
    output logic             fire_out,
    output logic             busy_out
);
    pd_in_s raw_in, sync_in, rise_in;
    logic [CNT_W-1:0] run_cnt, run_target;

    assign raw_in.start = start_in;
    assign raw_in.pulse = pulse_in;

    pdec_sync #(.W(PD_IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_in)
    );

    pdec_edge #(.W(PD_IN_W)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (sync_in),
        .rise (rise_in)
    );

    pdec_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_rise (rise_in.start),
        .pulse_rise (rise_in.pulse),
        .ratio      (ratio_in),
        .fire       (fire_out),
        .busy       (busy_out),
        .cnt        (run_cnt),
        .target     (run_target)
    );
endmodule

// File: rtl/pulse_decimator_chk.sv
module pulse_decimator_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fire,
    input logic             busy,
    input logic             pulse_rise,
    input logic             start_rise,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] target
);
    assert_fire_single_R8: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    assert_fire_ends_busy_R6: assert property (@(posedge clk) disable iff (rst)
        fire |-> (!busy && $past(busy)));

    assert_idle_ignores_R2: assert property (@(posedge clk) disable iff (rst)
        (!busy && pulse_rise && !start_rise) |=> !fire);

    assert_count_holds_R1: assert property (@(posedge clk) disable iff (rst)
        (busy && !pulse_rise) |=> (cnt == $past(cnt)));

    assert_target_kept_R5: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(target)));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cnt < target));

    assert_reset_quiet_R7: assert property (@(posedge clk)
        rst |-> (!busy && !fire));
endmodule

bind pulse_decimator pulse_decimator_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fire       (fire_out),
    .busy       (busy_out),
    .pulse_rise (rise_in.pulse),
    .start_rise (rise_in.start),
    .cnt        (run_cnt),
    .target     (run_target)
);

// File: tb/pulse_decimator_bench.sv
module pulse_decimator_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_in = 1'b0;
    logic        pulse_in = 1'b0;
    logic [15:0] ratio_in = 16'd0;
    logic        fire_out, busy_out;

    int compared = 0;
    int mismatched = 0;
    int fire_total = 0;
    int double_fire = 0;
    logic fire_prev = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit done = 0;

    always #5 clk = ~clk;

    pulse_decimator u_pulse_decimator (
        .clk      (clk),
        .rst      (rst),
        .start_in (start_in),
        .pulse_in (pulse_in),
        .ratio_in (ratio_in),
        .fire_out (fire_out),
        .busy_out (busy_out)
    );

    // Output monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (fire_out) fire_total++;
        if (fire_out && fire_prev) double_fire++;
        fire_prev <= fire_out;
    end

    // Each entry: ratio programmed, pulses expected before the output fires
    localparam int NVEC = 7;
    localparam int VEC [NVEC][2] = '{
        '{1, 1}, '{2, 2}, '{5, 5}, '{0, 1}, '{17, 17}, '{3, 3}, '{300, 300}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic send_pulse(input int width);
        @(negedge clk);
        pulse_in = 1'b1;
        cycles(width);
        pulse_in = 1'b0;
        step_lfsr();
        cycles(3 + int'(lfsr[2:0]));
    endtask

    task automatic send_random(input int n);
        for (int i = 0; i < n; i++) begin
            step_lfsr();
            send_pulse(2 + int'(lfsr[1:0] % 3));
        end
    endtask

    task automatic do_start(input logic [15:0] r);
        @(negedge clk);
        ratio_in = r;
        start_in = 1'b1;
        cycles(3);
        start_in = 1'b0;
        cycles(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog (all) actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int base;
        cycles(3);
        check(fire_out == 1'b0 && busy_out == 1'b0, "R7 reset state", {fire_out, busy_out}, 0);
        @(negedge clk) rst = 1'b0;
        cycles(3);

        // R2: pulses without start
        base = fire_total;
        send_random(6);
        check(fire_total == base, "R2 no fire while idle", fire_total - base, 0);
        check(busy_out == 1'b0, "R2 stays idle", busy_out, 0);

        // Table-driven runs
        for (int v = 0; v < NVEC; v++) begin
            string tag;
            tag = (VEC[v][0] == 0) ? "R4" : "R3";
            do_start(16'(VEC[v][0]));
            check(busy_out == 1'b1, "R6 busy after start", busy_out, 1);
            base = fire_total;
            send_random(VEC[v][1] - 1);
            check(fire_total == base, {tag, " not early"}, fire_total - base, 0);
            check(busy_out == 1'b1, "R6 busy during run", busy_out, 1);
            send_random(1);
            cycles(4);
            check(fire_total == base + 1, {tag, " fires after ratio pulses"}, fire_total - base, 1);
            check(busy_out == 1'b0, "R6 idle after fire", busy_out, 0);
        end

        // R1: one long pulse counts once
        do_start(16'd2);
        base = fire_total;
        send_pulse(25);
        check(fire_total == base && busy_out, "R1 long pulse counts once", fire_total - base, 0);
        send_pulse(2);
        cycles(4);
        check(fire_total == base + 1, "R1 second pulse completes", fire_total - base, 1);

        // R5: restart during run ignored
        do_start(16'd4);
        base = fire_total;
        send_random(2);
        do_start(16'd4);
        send_random(2);
        cycles(4);
        check(fire_total == base + 1, "R5 restart ignored", fire_total - base, 1);

        // R5: ratio change mid-run ignored
        do_start(16'd3);
        ratio_in = 16'd1;
        base = fire_total;
        send_random(1);
        cycles(4);
        check(fire_total == base, "R5 ratio latched (no early)", fire_total - base, 0);
        send_random(2);
        cycles(4);
        check(fire_total == base + 1, "R5 ratio latched (fires at 3)", fire_total - base, 1);

        // R7: asynchronous abort mid-run
        do_start(16'd5);
        send_random(2);
        @(negedge clk);
        #2 rst = 1'b1;
        #1;
        check(busy_out == 1'b0 && fire_out == 1'b0, "R7 async abort", busy_out, 0);
        cycles(2);
        rst = 1'b0;
        base = fire_total;
        send_random(6);
        check(fire_total == base && busy_out == 1'b0, "R7 idle after abort", fire_total - base, 0);

        check(double_fire == 0, "R8 single-cycle fire", double_fire, 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule